// File: doc/BRIEF.md
# Write-Protected Two-Level Pin Function Registers

This block holds the function selection and pad settings for a bank of multiplexed pins. Software reaches it through a single-cycle register bus: an address, a write strobe, write data and combinational read data. There are two banks of per-pin words. The first bank selects a direct function code and sets the pull and drive-strength codes. The second bank holds an extended function code, plus two selectors that pick the source for each of two management-data channels.

A pin whose first-level code is the reserved hand-off value takes its function from the second bank. For every pin the block drives one resolved function number, and it also drives the raw pull and drive codes. Each bank has its own protect register. A bank accepts writes only after it has been opened with a key. The key is the bus address of that bank's own protect register, and writing the key alone closes the bank again.

Top module: `pmx_regs`

## Requirements
- R1: With the default parameters, the first bank starts at 0x0000 and the second at 0x1000. The word for pin i sits at bank base + 4*i, for i from 0 to NPINS-1 (default 170, so the last word is at +0x2A4). Each protect register is at bank base + 0x400. The second bank's channel 0 selector is at base + 0x404 and its channel 1 selector at base + 0x408.
- R2: After reset both banks are locked and every stored field and selector is zero. Every pin then resolves to function 0 with pull code 0 and drive code 0.
- R3: The key for a bank is its protect address as a 32-bit value (0x00000400 and 0x00001400). Writing key|1 unlocks the bank and writing the key locks it. A protect read returns the key, with bit 0 set while the bank is unlocked.
- R4: A protect write of any other value leaves the lock state unchanged.
- R5: While a bank is locked, writes to its pin words and selectors are dropped. Reads are always served.
- R6: In a first-bank word, bits [3:0] are the function code, bits [9:8] the pull code (0 none, 1 up, 3 down) and bits [11:10] the drive code (0..3 for 4, 6, 8, 12 mA). Other bits read as zero. The pull and drive outputs carry the stored codes unchanged.
- R7: A first-level code from 0 to 9 resolves to that number.
- R8: A first-level code of 0xF resolves to 10 plus the second-bank code, which is held in bits [5:0] of the second-bank word. This applies while that code is 61 or less.
- R9: A first-level code from 10 to 14 resolves to the invalid marker 127. So does a 0xF hand-off whose second-bank code is 62 or 63.
- R10: Each selector stores write-data bits [2:0] and reads them back in bits [2:0]. The output mdsel_o carries channel 0 in [2:0] and channel 1 in [5:3].
- R11: The following are unmapped: offsets that are not word-aligned, pin indices at or beyond NPINS, first-bank offsets 0x404 and 0x408, any other offset at or above 0x40C, and addresses outside both banks. Unmapped offsets read zero and ignore writes.
- R12: The two lock states are independent. Opening or closing one bank does not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pin_func_o | output | NPINS*7 | Resolved function per pin, pin i in bits [7i+6:7i] |
| pin_pull_o | output | NPINS*2 | Pull code per pin |
| pin_drive_o | output | NPINS*2 | Drive-strength code per pin |
| mdsel_o | output | 6 | Management-data source selectors, channel 1 above channel 0 |

## Verification
The bench probes the hand-off boundaries. It writes second-level codes 61 and 62, and first-level codes 9, 12 and 15. A design with an off-by-one range check would report 72 instead of 127, or treat code 10 as a direct function. It tries near-miss keys, writes to a locked bank, and opens one bank while the other stays closed. A design that decoded the key loosely or shared the lock would let a write through that should be dropped. It also writes to the gap offsets, to pin index NPINS and to unaligned addresses. A decoder that ignored the low address bits or the pin count would then corrupt a real pin word or return non-zero data.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int FUNC_W     = 7;
  localparam int L1_W       = 8;   // stored drive, pull, function
  localparam int L2_W       = 6;
  localparam int SEL_W      = 3;
  localparam int OFF_W      = 12;
  localparam int IDX_W      = 10;
  localparam logic [FUNC_W-1:0] FUNC_BAD = 7'h7F;
  localparam logic [3:0] L1_HANDOFF  = 4'hF;
  localparam logic [3:0] L1_LAST     = 4'd9;
  localparam logic [L2_W-1:0] L2_LAST = 6'd61;
  localparam logic [FUNC_W-1:0] L2_BIAS = 7'd10;
  localparam logic [OFF_W-1:0] OFF_PROT = 12'h400;
  localparam logic [OFF_W-1:0] OFF_SEL0 = 12'h404;
  localparam logic [OFF_W-1:0] OFF_SEL1 = 12'h408;

  typedef struct packed {
    logic [1:0] drive;
    logic [1:0] pull;
    logic [3:0] func;
  } l1_cfg_t;
endpackage

// File: rtl/pmx_key_lock.sv
module pmx_key_lock #(
  parameter logic [31:0] KEY = 32'h400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic        locked
);
  logic locked_d;

  always_comb begin
    locked_d = locked;
    if (wr_en) begin
      if (wdata == KEY)                  locked_d = 1'b1;
      else if (wdata == (KEY | 32'd1))   locked_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b1;
    else        locked <= locked_d;
  end
endmodule

// File: rtl/pmx_cfg_array.sv
module pmx_cfg_array
  import pmx_pkg::*;
#(
  parameter int NPINS = 170,
  parameter int W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [W-1:0]        wr_data,
  output logic [W-1:0]        rd_data,
  output logic [NPINS*W-1:0]  all_q
);
  logic [W-1:0] q [NPINS];

  for (genvar i = 0; i < NPINS; i++) begin : g_word
    logic         en;
    logic [W-1:0] d;
    assign en = wr_en && (idx == IDX_W'(i));
    assign d  = en ? wr_data : q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= d;
    end
    assign all_q[i*W +: W] = q[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NPINS; i++)
      if (idx == IDX_W'(i)) rd_data = q[i];
  end
endmodule

// File: rtl/pmx_resolve.sv
module pmx_resolve
  import pmx_pkg::*;
#(
  parameter int NPINS = 170
) (
  input  logic [NPINS*L1_W-1:0]   l1_all,
  input  logic [NPINS*L2_W-1:0]   l2_all,
  output logic [NPINS*FUNC_W-1:0] func_all,
  output logic [NPINS*2-1:0]      pull_all,
  output logic [NPINS*2-1:0]      drive_all
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    l1_cfg_t           c1;
    logic [L2_W-1:0]   c2;
    logic [FUNC_W-1:0] f;
    assign c1 = l1_all[i*L1_W +: L1_W];
    assign c2 = l2_all[i*L2_W +: L2_W];
    always_comb begin
      if (c1.func <= L1_LAST)
        f = FUNC_W'(c1.func);
      else if (c1.func == L1_HANDOFF && c2 <= L2_LAST)
        f = FUNC_W'(c2) + L2_BIAS;
      else
        f = FUNC_BAD;
    end
    assign func_all[i*FUNC_W +: FUNC_W] = f;
    assign pull_all[i*2 +: 2]  = c1.pull;
    assign drive_all[i*2 +: 2] = c1.drive;
  end
endmodule

// File: rtl/pmx_regs.sv
module pmx_regs
  import pmx_pkg::*;
#(
  parameter int NPINS      = 170,
  parameter int AW         = 16,
  parameter int BANK1_BASE = 'h0000,
  parameter int BANK2_BASE = 'h1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           bus_addr,
  input  logic                    bus_we,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [NPINS*FUNC_W-1:0] pin_func_o,
  output logic [NPINS*2-1:0]      pin_pull_o,
  output logic [NPINS*2-1:0]      pin_drive_o,
  output logic [2*SEL_W-1:0]      mdsel_o
);
  localparam logic [AW-1:0] B1 = AW'(BANK1_BASE);
  localparam logic [AW-1:0] B2 = AW'(BANK2_BASE);
  localparam logic [31:0] KEY1 = 32'(BANK1_BASE) + 32'h400;
  localparam logic [31:0] KEY2 = 32'(BANK2_BASE) + 32'h400;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q = rsync[1];

  // address decode
  logic             hit1, hit2, is_pin;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] widx;
  assign off    = bus_addr[OFF_W-1:0];
  assign widx   = off[OFF_W-1:2];
  assign hit1   = bus_addr[AW-1:OFF_W] == B1[AW-1:OFF_W];
  assign hit2   = bus_addr[AW-1:OFF_W] == B2[AW-1:OFF_W];
  assign is_pin = (off[1:0] == 2'b00) && (off < OFF_PROT) && (widx < IDX_W'(NPINS));

  logic lock1_q, lock2_q;
  logic wr1_pin, wr2_pin, wr1_prot, wr2_prot, wr_sel0, wr_sel1;
  assign wr1_prot = bus_we && hit1 && (off == OFF_PROT);
  assign wr2_prot = bus_we && hit2 && (off == OFF_PROT);
  assign wr1_pin  = bus_we && hit1 && is_pin && !lock1_q;
  assign wr2_pin  = bus_we && hit2 && is_pin && !lock2_q;
  assign wr_sel0  = bus_we && hit2 && (off == OFF_SEL0) && !lock2_q;
  assign wr_sel1  = bus_we && hit2 && (off == OFF_SEL1) && !lock2_q;

  pmx_key_lock #(.KEY(KEY1)) u_lock1 (
    .clk(clk), .rst_n(rst_q), .wr_en(wr1_prot), .wdata(bus_wdata), .locked(lock1_q));
  pmx_key_lock #(.KEY(KEY2)) u_lock2 (
    .clk(clk), .rst_n(rst_q), .wr_en(wr2_prot), .wdata(bus_wdata), .locked(lock2_q));

  // per-pin storage
  l1_cfg_t                 l1_wr, l1_rd;
  logic [L2_W-1:0]         l2_rd;
  logic [NPINS*L1_W-1:0]   l1_all;
  logic [NPINS*L2_W-1:0]   l2_all;
  assign l1_wr = '{drive: bus_wdata[11:10], pull: bus_wdata[9:8], func: bus_wdata[3:0]};

  pmx_cfg_array #(.NPINS(NPINS), .W(L1_W)) u_bank1 (
    .clk(clk), .rst_n(rst_q), .wr_en(wr1_pin), .idx(widx),
    .wr_data(l1_wr), .rd_data(l1_rd), .all_q(l1_all));
  pmx_cfg_array #(.NPINS(NPINS), .W(L2_W)) u_bank2 (
    .clk(clk), .rst_n(rst_q), .wr_en(wr2_pin), .idx(widx),
    .wr_data(bus_wdata[L2_W-1:0]), .rd_data(l2_rd), .all_q(l2_all));

  // management-data source selectors
  logic [SEL_W-1:0] sel0_q, sel1_q, sel0_d, sel1_d;
  assign sel0_d = wr_sel0 ? bus_wdata[SEL_W-1:0] : sel0_q;
  assign sel1_d = wr_sel1 ? bus_wdata[SEL_W-1:0] : sel1_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sel0_q <= '0;
      sel1_q <= '0;
    end else begin
      sel0_q <= sel0_d;
      sel1_q <= sel1_d;
    end
  end
  assign mdsel_o = {sel1_q, sel0_q};

  pmx_resolve #(.NPINS(NPINS)) u_resolve (
    .l1_all(l1_all), .l2_all(l2_all),
    .func_all(pin_func_o), .pull_all(pin_pull_o), .drive_all(pin_drive_o));

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit1) begin
      if (is_pin)                bus_rdata = {20'd0, l1_rd.drive, l1_rd.pull, 4'd0, l1_rd.func};
      else if (off == OFF_PROT)  bus_rdata = KEY1 | {31'd0, !lock1_q};
    end else if (hit2) begin
      if (is_pin)                bus_rdata = {{(32-L2_W){1'b0}}, l2_rd};
      else if (off == OFF_PROT)  bus_rdata = KEY2 | {31'd0, !lock2_q};
      else if (off == OFF_SEL0)  bus_rdata = {{(32-SEL_W){1'b0}}, sel0_q};
      else if (off == OFF_SEL1)  bus_rdata = {{(32-SEL_W){1'b0}}, sel1_q};
    end
  end
endmodule

// File: rtl/pmx_regs_chk.sv
module pmx_regs_chk
  import pmx_pkg::*;
#(
  parameter int NPINS      = 170,
  parameter int AW         = 16,
  parameter int BANK1_BASE = 'h0000,
  parameter int BANK2_BASE = 'h1000
) (
  input logic                    clk,
  input logic                    rst_q,
  input logic [AW-1:0]           bus_addr,
  input logic                    bus_we,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic                    lock1_q,
  input logic                    lock2_q,
  input logic [NPINS*FUNC_W-1:0] pin_func_o,
  input logic [NPINS*2-1:0]      pin_pull_o,
  input logic [NPINS*2-1:0]      pin_drive_o,
  input logic [2*SEL_W-1:0]      mdsel_o
);
  localparam logic [AW-1:0] P1 = AW'(BANK1_BASE + 'h400);
  localparam logic [AW-1:0] P2 = AW'(BANK2_BASE + 'h400);
  localparam logic [31:0] K1 = 32'(BANK1_BASE) + 32'h400;
  localparam logic [31:0] K2 = 32'(BANK2_BASE) + 32'h400;
  localparam logic [AW-1:0] B2 = AW'(BANK2_BASE);

  a_r5_pad_hold: assert property (@(posedge clk) disable iff (!rst_q)
    lock1_q |=> ($stable(pin_pull_o) && $stable(pin_drive_o)));

  a_r5_func_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (lock1_q && lock2_q) |=> $stable(pin_func_o));

  a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_q)
    lock2_q |=> $stable(mdsel_o));

  a_r3_open1: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == P1 && bus_wdata == (K1 | 32'd1)) |=> !lock1_q);

  a_r3_close2: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == P2 && bus_wdata == K2) |=> lock2_q);

  a_r4_other_key: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == P1 && bus_wdata != K1 && bus_wdata != (K1 | 32'd1))
      |=> $stable(lock1_q));

  a_r12_independent: assert property (@(posedge clk) disable iff (!rst_q)
    (!(bus_we && bus_addr == P2)) |=> $stable(lock2_q));

  a_r3_prot_read: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr == P1) |-> (bus_rdata == (K1 | {31'd0, !lock1_q})));

  a_r11_gap_read: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr[AW-1:OFF_W] == B2[AW-1:OFF_W] && bus_addr[OFF_W-1:0] >= 12'h40C)
      |-> (bus_rdata == 32'd0));

  always_comb begin
    if (rst_q) begin
      for (int i = 0; i < NPINS; i++) begin
        a_r9_func_range: assert (pin_func_o[i*FUNC_W +: FUNC_W] <= 7'd71 ||
                                 pin_func_o[i*FUNC_W +: FUNC_W] == FUNC_BAD)
          else $error("resolved function out of range on pin %0d", i);
      end
    end
  end
endmodule

bind pmx_regs pmx_regs_chk #(
  .NPINS(NPINS), .AW(AW), .BANK1_BASE(BANK1_BASE), .BANK2_BASE(BANK2_BASE)
) u_chk (
  .clk(clk), .rst_q(rst_q), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock1_q(lock1_q),
  .lock2_q(lock2_q), .pin_func_o(pin_func_o), .pin_pull_o(pin_pull_o),
  .pin_drive_o(pin_drive_o), .mdsel_o(mdsel_o)
);

// File: tb/pmx_regs_tb.sv
module pmx_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 170;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NPINS*7-1:0] pin_func_o;
  logic [NPINS*2-1:0] pin_pull_o, pin_drive_o;
  logic [5:0]  mdsel_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmx_regs #(.NPINS(NPINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_func_o(pin_func_o),
    .pin_pull_o(pin_pull_o), .pin_drive_o(pin_drive_o), .mdsel_o(mdsel_o));

  // reference model
  logic [11:0] m1 [NPINS];
  logic [5:0]  m2 [NPINS];
  logic [2:0]  ms0, ms1;
  logic        mlk1, mlk2;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_func(logic [3:0] l1, logic [5:0] l2);
    if (l1 <= 4'd9) return {3'd0, l1};
    if (l1 == 4'hF && l2 <= 6'd61) return 7'(l2) + 7'd10;
    return 7'h7F;
  endfunction

  function automatic string func_tag(logic [3:0] l1, logic [5:0] l2);
    if (l1 <= 4'd9) return "R7 direct function";
    if (l1 == 4'hF && l2 <= 6'd61) return "R8 hand-off function";
    return "R9 invalid function";
  endfunction

  // bench decode, written from the address map
  function automatic int pin_of(logic [15:0] a, output bit b2);
    b2 = 0;
    if (a[15:12] > 4'd1) return -1;
    b2 = a[12];
    if (a[1:0] != 2'b00 || a[11:0] >= 12'h400) return -1;
    if (int'(a[11:2]) >= NPINS) return -1;
    return int'(a[11:2]);
  endfunction

  function automatic logic [31:0] model_read(logic [15:0] a);
    bit b2;
    int p;
    p = pin_of(a, b2);
    if (a[15:12] > 4'd1) return 32'd0;
    if (p >= 0) return b2 ? {26'd0, m2[p]} : {20'd0, m1[p]};
    if (a[11:0] == 12'h400) return b2 ? (32'h1400 | {31'd0, !mlk2}) : (32'h400 | {31'd0, !mlk1});
    if (b2 && a[11:0] == 12'h404) return {29'd0, ms0};
    if (b2 && a[11:0] == 12'h408) return {29'd0, ms1};
    return 32'd0;
  endfunction

  function automatic void model_write(logic [15:0] a, logic [31:0] d);
    bit b2;
    int p;
    p = pin_of(a, b2);
    if (a[15:12] > 4'd1) return;
    if (p >= 0) begin
      if (!b2 && !mlk1) m1[p] = d[11:0] & 12'hF0F;
      if (b2 && !mlk2)  m2[p] = d[5:0];
    end else if (a[11:0] == 12'h400) begin
      if (d == (b2 ? 32'h1400 : 32'h400)) begin if (b2) mlk2 = 1; else mlk1 = 1; end
      if (d == (b2 ? 32'h1401 : 32'h401)) begin if (b2) mlk2 = 0; else mlk1 = 0; end
    end else if (b2 && !mlk2 && a[11:0] == 12'h404) ms0 = d[2:0];
    else if (b2 && !mlk2 && a[11:0] == 12'h408) ms1 = d[2:0];
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(logic [15:0] a, string tag);
    bus_addr = a; bus_we = 1'b0;
    #1;
    check(tag, bus_rdata, model_read(a));
  endtask

  task automatic check_pin(int p);
    check(func_tag(m1[p][3:0], m2[p]), 32'(pin_func_o[p*7 +: 7]),
          32'(exp_func(m1[p][3:0], m2[p])));
    check("R6 pull code", 32'(pin_pull_o[p*2 +: 2]), 32'(m1[p][9:8]));
    check("R6 drive code", 32'(pin_drive_o[p*2 +: 2]), 32'(m1[p][11:10]));
  endtask

  task automatic check_sel(string tag);
    check(tag, 32'(mdsel_o), {26'd0, ms1, ms0});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NPINS; i++) begin m1[i] = '0; m2[i] = '0; end
    ms0 = '0; ms1 = '0; mlk1 = 1; mlk2 = 1;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    rd(16'h0400, "R2 bank1 locked after reset");
    rd(16'h1400, "R2 bank2 locked after reset");
    rd(16'h0000, "R2 pin word zero");
    check_pin(0);
    check_sel("R2 selectors zero");

    // R5 locked writes dropped
    wr(16'h0014, 32'h0000_0B07);
    rd(16'h0014, "R5 locked bank1 write dropped");
    check_pin(5);

    // R4 near-miss keys
    wr(16'h0400, 32'h0000_0403);
    rd(16'h0400, "R4 wrong key keeps lock");
    wr(16'h0400, 32'h0001_0401);
    rd(16'h0400, "R4 high-bit key keeps lock");

    // R3 unlock bank1, R12 bank2 unaffected
    wr(16'h0400, 32'h0000_0401);
    rd(16'h0400, "R3 bank1 unlocked");
    rd(16'h1400, "R12 bank2 still locked");

    // R6 fields, R7 direct
    wr(16'h0014, 32'h0000_0B07);
    rd(16'h0014, "R6 field readback");
    check_pin(5);
    wr(16'h0014, 32'hFFFF_F0F2);
    rd(16'h0014, "R6 unused bits read zero");
    check_pin(5);
    wr(16'h0010, 32'h0000_0009);
    check_pin(4);

    // R8 / R9 hand-off
    wr(16'h0018, 32'h0000_000F);
    check_pin(6);
    wr(16'h1018, 32'd61);
    rd(16'h1018, "R5 locked bank2 write dropped");
    wr(16'h1400, 32'h0000_1401);
    rd(16'h1400, "R3 bank2 unlocked");
    wr(16'h1018, 32'd61);
    check(func_tag(4'hF, 6'd61), 32'(pin_func_o[6*7 +: 7]), 32'd71);
    wr(16'h1018, 32'd62);
    check("R9 second-level 62 invalid", 32'(pin_func_o[6*7 +: 7]), 32'h7F);
    wr(16'h001C, 32'h0000_000C);
    check("R9 first-level 12 invalid", 32'(pin_func_o[7*7 +: 7]), 32'h7F);
    wr(16'h0020, 32'h0000_000A);
    check("R9 first-level 10 invalid", 32'(pin_func_o[8*7 +: 7]), 32'h7F);

    // R10 selectors
    wr(16'h1404, 32'd5);
    wr(16'h1408, 32'hFFFF_FFFA);
    rd(16'h1404, "R10 selector 0 readback");
    rd(16'h1408, "R10 selector 1 readback");
    check_sel("R10 selector outputs");

    // R1 boundary pins
    wr(16'h02A4, 32'h0000_0F0F);
    wr(16'h12A4, 32'd3);
    rd(16'h02A4, "R1 last pin word");
    check(func_tag(4'hF, 6'd3), 32'(pin_func_o[169*7 +: 7]), 32'd13);

    // R11 unmapped
    wr(16'h02A8, 32'h0000_0F01);
    rd(16'h02A8, "R11 pin index beyond NPINS");
    wr(16'h0404, 32'h0000_0007);
    rd(16'h0404, "R11 bank1 selector gap");
    wr(16'h0015, 32'h0000_0003);
    rd(16'h0015, "R11 unaligned");
    rd(16'h0014, "R11 unaligned write did not alter pin 5");
    wr(16'h3014, 32'h0000_0001);
    rd(16'h3014, "R11 outside banks");
    wr(16'h140C, 32'h0000_0007);
    rd(16'h140C, "R11 bank2 gap");
    check_sel("R11 selectors unchanged");

    // R5 selector dropped after relock, R3 relock
    wr(16'h1400, 32'h0000_1400);
    rd(16'h1400, "R3 bank2 relocked");
    wr(16'h1404, 32'd2);
    check_sel("R5 locked selector write dropped");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int kind;
      int p;
      logic [15:0] a;
      logic [31:0] d;
      kind = int'($urandom_range(0, 9));
      p = int'($urandom_range(0, NPINS - 1));
      d = $urandom();
      case (kind)
        0, 1, 2: a = 16'(p * 4);
        3, 4:    a = 16'h1000 | 16'(p * 4);
        5: begin
          a = $urandom_range(0, 1) ? 16'h1400 : 16'h0400;
          case ($urandom_range(0, 2))
            0: d = 32'(a);
            1: d = 32'(a) | 32'd1;
            default: d = 32'(a) ^ 32'(1 << $urandom_range(1, 31));
          endcase
        end
        6: a = $urandom_range(0, 1) ? 16'h1404 : 16'h1408;
        7: a = 16'($urandom_range(0, 16'h1FFF));
        default: a = 16'(p * 4);
      endcase
      if (kind == 9) rd(a, "R1 random read");
      else wr(a, d);
      check_pin(p);
      rd(16'(p * 4), "R5 random bank1 read");
      rd(16'h1000 | 16'(p * 4), "R8 random bank2 read");
      rd(16'h0400, "R12 random bank1 lock");
      rd(16'h1400, "R12 random bank2 lock");
      check_sel("R10 random selectors");
    end

    for (int i = 0; i < NPINS; i++) check_pin(i);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule